// File: doc/BRIEF.md
# Calendar Real-Time Clock with Update Flag

This block keeps wall-clock time in six byte registers (second, minute, hour, day of month, month and a two-digit year) and advances them once per second. Its timebase is a clock-enable `tick` input, and a prescaler counts `TPS` ticks to one second. Software reaches every register through a small port with an address, a write strobe and write data. Read data is combinational on the address.

Each second advance is framed by an update flag. The flag rises `LEAD` ticks before the time registers change. It stays high for `TAIL` ticks after the change, and during that tail every time register reads as the poison byte 0xFF. Software that checks the flag before and after a readout can therefore tell whether the values it read are coherent.

A control register chooses the storage format, BCD or binary. It also holds a freeze bit that suppresses updates while software loads a new time. A divider-hold bit in the status register keeps the prescaler at zero.

Top module: `cal_rtc`

## Requirements
- R1: After reset, second, minute, hour and year read 0x00. Day and month read 0x01. Control (address 0x0B) and status (address 0x0A) read 0x00.
- R2: The seconds register advances by exactly one once every `TPS` ticks. Successive rising edges of the update flag are exactly `TPS` ticks apart.
- R3: The update flag is status bit 7. It rises exactly `LEAD` ticks before the time registers change. During those `LEAD` ticks the time registers still read their old, valid values.
- R4: After the change the flag stays high for exactly `TAIL` more ticks. During that tail every time register reads 0xFF, and the flag is still high.
- R5: In BCD mode (control bit 2 clear) the carry chain runs through all fields. 23:59:59 on day 0x31, month 0x12, year 0x99 becomes 00:00:00 on day 0x01, month 0x01, year 0x00. Hours count 0 to 23.
- R6: With control bit 2 set, the registers hold binary values. Second 0x3B, minute 0x3B, hour 0x0A becomes second 0x00, minute 0x00, hour 0x0B.
- R7: Day-of-month rollover follows the month length. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R8: While control bit 7 (freeze) is set, no update happens, the flag stays low and the time registers keep their values. Setting freeze while the flag is high aborts that update. Clearing freeze resumes counting.
- R9: Status bit 4 (divider hold) reads back as written. While it is set, the prescaler is held at zero and no update happens. After it is released, the flag first rises after `TPS-LEAD` ticks, counting the tick in the release cycle.
- R10: A freeze write in the cycle where the flag would rise keeps the flag low. A write to a time register in the cycle where the registers advance replaces the advanced value of that register only.
- R11: Writes to status bit 7 are ignored. Addresses 0x0C to 0x0F, and all addresses other than 0x00, 0x02, 0x04, 0x07, 0x08, 0x09, 0x0A and 0x0B, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for the prescaler, one unit of time |
| addr | input | 4 | Register address for both read and write |
| wr_en | input | 1 | Write strobe, applies `wdata` to `addr` at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` (combinational) |

## Verification
Two events can land on the same edge: a software write and a timer event. The first pairing is a write to the minute register on the exact edge where the seconds roll from 59 and would carry into the minutes. The second is a freeze write on the exact edge where the update flag would rise. The bench runs the tick on every cycle for these cases and counts ticks from an observed flag rise, so each write lands on the intended edge. It then judges the minute and hour values read after the update, and the flag and seconds values over the following two seconds.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam logic [3:0] ADDR_SEC  = 4'h0;
    localparam logic [3:0] ADDR_MIN  = 4'h2;
    localparam logic [3:0] ADDR_HR   = 4'h4;
    localparam logic [3:0] ADDR_DAY  = 4'h7;
    localparam logic [3:0] ADDR_MON  = 4'h8;
    localparam logic [3:0] ADDR_YR   = 4'h9;
    localparam logic [3:0] ADDR_STA  = 4'hA;
    localparam logic [3:0] ADDR_CTL  = 4'hB;

    localparam int CTL_FREEZE_BIT = 7;
    localparam int CTL_BIN_BIT    = 2;
    localparam int STA_FLAG_BIT   = 7;
    localparam int STA_HOLD_BIT   = 4;

    localparam logic [7:0] POISON = 8'hFF;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] yr;
    } cal_t;

    typedef struct packed {
        logic freeze;
        logic bin;
        logic hold;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] from_bin(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return {4'(v / 8'd10), 4'(v % 8'd10)};
    endfunction

    function automatic logic [7:0] days_in(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import cal_rtc_pkg::*;
#(
    parameter int TPS  = 32,
    parameter int LEAD = 3,
    parameter int TAIL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic inhibit_i,
    output logic uip_o,
    output logic poison_o,
    output logic adv_o
);

    localparam int CW = $clog2(TPS);
    localparam int TW = $clog2(TAIL + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TPS - 1);
    localparam logic [CW-1:0] CNT_RISE = CW'(TPS - LEAD);
    localparam logic [TW-1:0] TAIL_LD  = TW'(TAIL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        phase_e        phase;
        logic [TW-1:0] tail;
    } pre_t;

    pre_t s_d, s_q;
    logic [CW-1:0] cnt_nx;
    logic          adv;

    always_comb begin
        s_d    = s_q;
        adv    = 1'b0;
        cnt_nx = (s_q.cnt == CNT_LAST) ? '0 : s_q.cnt + 1'b1;
        if (hold_i) begin
            s_d.cnt   = '0;
            s_d.phase = PH_IDLE;
            s_d.tail  = '0;
        end else begin
            if (tick_i) s_d.cnt = cnt_nx;
            if (inhibit_i) begin
                s_d.phase = PH_IDLE;
                s_d.tail  = '0;
            end else if (tick_i) begin
                case (s_q.phase)
                    PH_IDLE: if (cnt_nx == CNT_RISE) s_d.phase = PH_LEAD;
                    PH_LEAD: if (s_q.cnt == CNT_LAST) begin
                        adv       = 1'b1;
                        s_d.phase = PH_TAIL;
                        s_d.tail  = TAIL_LD;
                    end
                    PH_TAIL: begin
                        if (s_q.tail == '0) s_d.phase = PH_IDLE;
                        else                s_d.tail  = s_q.tail - 1'b1;
                    end
                    default: s_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cnt: '0, phase: PH_IDLE, tail: '0};
        else        s_q <= s_d;
    end

    assign uip_o    = (s_q.phase != PH_IDLE);
    assign poison_o = (s_q.phase == PH_TAIL);
    assign adv_o    = adv;

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!uip_o && s_q.cnt == '0));

    // R3
    lead_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_o) |-> !poison_o);

    // R4
    tail_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> (uip_o && poison_o));

    // R8
    inhibit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !uip_o);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import cal_rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       bin_i,
    input  logic       wr_i,
    input  logic [3:0] waddr_i,
    input  logic [7:0] wdata_i,
    output cal_t       cal_o
);

    cal_t cal_d, cal_q;
    logic [7:0] b_sec, b_min, b_hr, b_day, b_mon, b_yr;

    assign b_sec = to_bin(cal_q.sec, bin_i);
    assign b_min = to_bin(cal_q.min, bin_i);
    assign b_hr  = to_bin(cal_q.hr,  bin_i);
    assign b_day = to_bin(cal_q.day, bin_i);
    assign b_mon = to_bin(cal_q.mon, bin_i);
    assign b_yr  = to_bin(cal_q.yr,  bin_i);

    always_comb begin
        cal_d = cal_q;
        if (adv_i) begin
            if (b_sec < 8'd59) begin
                cal_d.sec = from_bin(b_sec + 8'd1, bin_i);
            end else begin
                cal_d.sec = from_bin(8'd0, bin_i);
                if (b_min < 8'd59) begin
                    cal_d.min = from_bin(b_min + 8'd1, bin_i);
                end else begin
                    cal_d.min = from_bin(8'd0, bin_i);
                    if (b_hr < 8'd23) begin
                        cal_d.hr = from_bin(b_hr + 8'd1, bin_i);
                    end else begin
                        cal_d.hr = from_bin(8'd0, bin_i);
                        if (b_day < days_in(b_mon, b_yr)) begin
                            cal_d.day = from_bin(b_day + 8'd1, bin_i);
                        end else begin
                            cal_d.day = from_bin(8'd1, bin_i);
                            if (b_mon < 8'd12) begin
                                cal_d.mon = from_bin(b_mon + 8'd1, bin_i);
                            end else begin
                                cal_d.mon = from_bin(8'd1, bin_i);
                                cal_d.yr  = (b_yr < 8'd99) ? from_bin(b_yr + 8'd1, bin_i)
                                                           : from_bin(8'd0, bin_i);
                            end
                        end
                    end
                end
            end
        end
        if (wr_i) begin
            case (waddr_i)
                ADDR_SEC: cal_d.sec = wdata_i;
                ADDR_MIN: cal_d.min = wdata_i;
                ADDR_HR:  cal_d.hr  = wdata_i;
                ADDR_DAY: cal_d.day = wdata_i;
                ADDR_MON: cal_d.mon = wdata_i;
                ADDR_YR:  cal_d.yr  = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                               day: 8'h01, mon: 8'h01, yr: 8'h00};
        else        cal_q <= cal_d;
    end

    assign cal_o = cal_q;

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wr_i) |=> (cal_q.sec != $past(cal_q.sec)));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !wr_i) |=> $stable(cal_q));

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int TPS  = 32,
    parameter int LEAD = 3,
    parameter int TAIL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    ctl_t ctl_d, ctl_q;
    cal_t cal;
    logic uip, poison, adv;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && addr == ADDR_CTL) begin
            ctl_d.freeze = wdata[CTL_FREEZE_BIT];
            ctl_d.bin    = wdata[CTL_BIN_BIT];
        end
        if (wr_en && addr == ADDR_STA) ctl_d.hold = wdata[STA_HOLD_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rtc_prescaler #(.TPS(TPS), .LEAD(LEAD), .TAIL(TAIL)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .hold_i    (ctl_d.hold),
        .inhibit_i (ctl_d.freeze),
        .uip_o     (uip),
        .poison_o  (poison),
        .adv_o     (adv)
    );

    rtc_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .bin_i   (ctl_q.bin),
        .wr_i    (wr_en),
        .waddr_i (addr),
        .wdata_i (wdata),
        .cal_o   (cal)
    );

    always_comb begin
        rdata = 8'h00;
        case (addr)
            ADDR_SEC: rdata = poison ? POISON : cal.sec;
            ADDR_MIN: rdata = poison ? POISON : cal.min;
            ADDR_HR:  rdata = poison ? POISON : cal.hr;
            ADDR_DAY: rdata = poison ? POISON : cal.day;
            ADDR_MON: rdata = poison ? POISON : cal.mon;
            ADDR_YR:  rdata = poison ? POISON : cal.yr;
            ADDR_STA: begin
                rdata[STA_FLAG_BIT] = uip;
                rdata[STA_HOLD_BIT] = ctl_q.hold;
            end
            ADDR_CTL: begin
                rdata[CTL_FREEZE_BIT] = ctl_q.freeze;
                rdata[CTL_BIN_BIT]    = ctl_q.bin;
            end
            default: rdata = 8'h00;
        endcase
    end

    // R10
    freeze_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTL && wdata[CTL_FREEZE_BIT]) |=> !uip);

endmodule

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;

    localparam int TPS  = 32;
    localparam int LEAD = 3;
    localparam int TAIL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fast = 1'b0;
    int         tcnt = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    cal_rtc #(.TPS(TPS), .LEAD(LEAD), .TAIL(TAIL)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    always #4 clk = ~clk;
    always @(negedge clk) tick <= fast ? 1'b1 : ~tick;
    always @(posedge clk) if (tick) tcnt <= tcnt + 1;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic peek(input logic [3:0] a, output logic f, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
        addr = 4'hA;
        #1 f = rdata[7];
    endtask

    task automatic wait_rise(output int t, output logic [7:0] v);
        logic f, prev;
        @(negedge clk);
        peek(4'h0, prev, v);
        t = -1;
        for (int i = 0; i < 8 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, v);
            if (!prev && f) begin t = tcnt; break; end
            prev = f;
        end
        if (t < 0) chk("wait_rise timeout", 0, 1);
    endtask

    task automatic wait_fall(output int t, output logic [7:0] v);
        logic f;
        t = -1;
        for (int i = 0; i < 8 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, v);
            if (!f) begin t = tcnt; break; end
        end
        if (t < 0) chk("wait_fall timeout", 0, 1);
    endtask

    task automatic one_update();
        int t; logic [7:0] v;
        wait_rise(t, v);
        wait_fall(t, v);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d, mo, y, input logic bin);
        wr(4'hB, {1'b1, 4'b0, bin, 2'b0});
        wr(4'h0, s); wr(4'h2, m); wr(4'h4, h);
        wr(4'h7, d); wr(4'h8, mo); wr(4'h9, y);
        wr(4'hB, {1'b0, 4'b0, bin, 2'b0});
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'h0, v); chk("R1 sec", v, 8'h00);
        rd(4'h2, v); chk("R1 min", v, 8'h00);
        rd(4'h4, v); chk("R1 hr", v, 8'h00);
        rd(4'h7, v); chk("R1 day", v, 8'h01);
        rd(4'h8, v); chk("R1 mon", v, 8'h01);
        rd(4'h9, v); chk("R1 yr", v, 8'h00);
        rd(4'hB, v); chk("R1 ctl", v, 8'h00);
        rd(4'hA, v); chk("R1 sta", v, 8'h00);
    endtask

    task automatic t_timing();
        int t0, t1, t2, t3; logic [7:0] v; logic f;
        set_time(8'h10, 8'h20, 8'h08, 8'h15, 8'h06, 8'h22, 1'b0);
        wait_rise(t0, v);
        chk("R3 valid during lead", v, 8'h10);
        t1 = -1;
        for (int i = 0; i < 4 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, v);
            if (v != 8'h10) begin t1 = tcnt; break; end
        end
        chk("R4 poison after change", v, 8'hFF);
        chk("R4 flag high in tail", f, 1);
        chk("R3 lead ticks", t1 - t0, LEAD);
        wait_fall(t2, v);
        chk("R4 tail ticks", t2 - t1, TAIL);
        chk("R2 sec advanced by one", v, 8'h11);
        wait_rise(t3, v);
        chk("R2 period ticks", t3 - t0, TPS);
    endtask

    task automatic t_carry_bcd();
        logic [7:0] v;
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 1'b0);
        one_update();
        rd(4'h0, v); chk("R5 sec", v, 8'h00);
        rd(4'h2, v); chk("R5 min", v, 8'h00);
        rd(4'h4, v); chk("R5 hr", v, 8'h00);
        rd(4'h7, v); chk("R5 day", v, 8'h01);
        rd(4'h8, v); chk("R5 mon", v, 8'h01);
        rd(4'h9, v); chk("R5 yr", v, 8'h00);
    endtask

    task automatic t_binary();
        logic [7:0] v;
        set_time(8'h3B, 8'h3B, 8'h0A, 8'h05, 8'h03, 8'h10, 1'b1);
        rd(4'hB, v); chk("R6 ctl readback", v, 8'h04);
        one_update();
        rd(4'h0, v); chk("R6 sec", v, 8'h00);
        rd(4'h2, v); chk("R6 min", v, 8'h00);
        rd(4'h4, v); chk("R6 hr", v, 8'h0B);
        wr(4'hB, 8'h00);
    endtask

    task automatic t_month();
        logic [7:0] v;
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 1'b0);
        one_update();
        rd(4'h7, v); chk("R7 feb28 common day", v, 8'h01);
        rd(4'h8, v); chk("R7 feb28 common mon", v, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 1'b0);
        one_update();
        rd(4'h7, v); chk("R7 feb28 leap day", v, 8'h29);
        rd(4'h8, v); chk("R7 feb28 leap mon", v, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24, 1'b0);
        one_update();
        rd(4'h7, v); chk("R7 apr30 day", v, 8'h01);
        rd(4'h8, v); chk("R7 apr30 mon", v, 8'h05);
    endtask

    task automatic t_freeze();
        logic [7:0] v; logic f; int seen, t;
        wr(4'hB, 8'h80);
        wr(4'h0, 8'h42);
        seen = 0;
        for (int i = 0; i < 4 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, v);
            if (f) seen++;
        end
        chk("R8 no flag while frozen", seen, 0);
        chk("R8 sec held while frozen", v, 8'h42);
        wr(4'hB, 8'h00);
        one_update();
        rd(4'h0, v); chk("R8 resumes after clear", v, 8'h43);
        wait_rise(t, v);
        wr(4'hB, 8'h80);
        rd(4'hA, v); chk("R8 abort clears flag", v[7], 0);
        for (int i = 0; i < 3 * TPS; i++) @(negedge clk);
        rd(4'h0, v); chk("R8 aborted update no change", v, 8'h43);
        wr(4'hB, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v; logic f; int seen, tb, tr;
        wr(4'hA, 8'h10);
        rd(4'hA, v); chk("R9 hold readback", v, 8'h10);
        rd(4'h0, v);
        seen = 0;
        for (int i = 0; i < 4 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, wdata);
            if (f) seen++;
        end
        chk("R9 no flag while held", seen, 0);
        rd(4'h0, wdata);
        chk("R9 sec held", wdata, v);
        @(negedge clk);
        addr = 4'hA; wdata = 8'h00; wr_en = 1'b1; tb = tcnt;
        @(negedge clk);
        wr_en = 1'b0;
        wait_rise(tr, v);
        chk("R9 first rise after release", tr - tb, TPS - LEAD);
    endtask

    task automatic t_coincide();
        logic [7:0] v; logic f; int tp, seen;
        fast = 1'b1;
        set_time(8'h59, 8'h34, 8'h12, 8'h10, 8'h07, 8'h30, 1'b0);
        wait_rise(tp, v);
        while (tcnt != tp + LEAD - 1) @(negedge clk);
        addr = 4'h2; wdata = 8'h10; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_fall(seen, v);
        chk("R10 sec still advanced", v, 8'h00);
        rd(4'h2, v); chk("R10 write beats carry min", v, 8'h10);
        rd(4'h4, v); chk("R10 hr untouched", v, 8'h12);
        while (tcnt != tp + TPS - 1) @(negedge clk);
        addr = 4'hB; wdata = 8'h80; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr = 4'hA;
        #1 chk("R10 freeze at rise edge", rdata[7], 0);
        seen = 0;
        for (int i = 0; i < 2 * TPS; i++) begin
            @(negedge clk);
            peek(4'h0, f, v);
            if (f) seen++;
        end
        chk("R10 no flag after freeze", seen, 0);
        chk("R10 sec unchanged after freeze", v, 8'h00);
        wr(4'hB, 8'h00);
        fast = 1'b0;
    endtask

    task automatic t_map();
        logic [7:0] v; int t;
        wait_fall(t, v);
        wr(4'hA, 8'h80);
        rd(4'hA, v); chk("R11 flag bit not writable", v, 8'h00);
        rd(4'h5, v); chk("R11 unmapped 0x05", v, 8'h00);
        rd(4'hC, v); chk("R11 unmapped 0x0C", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_carry_bcd();
        t_binary();
        t_month();
        t_freeze();
        t_hold();
        t_coincide();
        t_map();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule